// File: doc/BRIEF.md
# Registered Odd-Parity Generator with Serial Load

This block reduces a twelve-bit data word to a single odd-parity bit and presents that bit on a combinational output. A high level on a force input pins that output low whatever the data. Alongside the combinational path sits a one-bit output register. On each clock edge it takes its next value from one of three places. It can reload the gated parity result, take a bit from a serial input when shifting, or keep what it already holds.

The register is clocked by the logical OR of two clock inputs, so a rising edge on either input, or on both together, advances it. A high level on the reset input clears the register at once, with no clock edge needed, and holds it clear for as long as reset stays high. Chaining the registered output of one block into the serial input of the next forms a shift chain of parity results.

Top module: `par_shift_gen`

## Requirements
- R1: `par_o` is 1 exactly when an odd number of the bits of `data_i` are 1 and `force_lo_i` is 0. An all-zero word and an all-one twelve-bit word both give 0.
- R2: While `force_lo_i` is 1, `par_o` is 0 for every value of `data_i`.
- R3: On a register clock edge with `hold_n_i` at 0, `reg_o` keeps its present value.
- R4: The hold input has priority over shift. With `hold_n_i` at 0 and `shift_i` at 1, a clock edge leaves `reg_o` unchanged, even when `ser_i` differs from it.
- R5: On a register clock edge with `hold_n_i` at 1 and `shift_i` at 1, `reg_o` takes the value of `ser_i`.
- R6: On a register clock edge with `hold_n_i` at 1 and `shift_i` at 0, `reg_o` takes the value `par_o` had just before the edge. While `force_lo_i` is 1, that value is 0.
- R7: A register clock edge is a rising edge of `clk_a_i`, a rising edge of `clk_b_i`, or of both at once. Each kind updates `reg_o` in the same way.
- R8: While `rst_i` is 1, `reg_o` is 0. It goes to 0 as soon as `rst_i` rises, without a clock edge, and clock edges during reset do not change it.
- R9: When `rst_i` falls between clock edges, `reg_o` stays 0 until the next register clock edge, which then loads as R3 to R6 describe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 12 (DATA_W) | Data word covered by the parity |
| force_lo_i | input | 1 | 1 forces the combinational parity output to 0 |
| hold_n_i | input | 1 | Active-low hold; 0 keeps the register value |
| shift_i | input | 1 | 1 selects the serial input as the register source |
| ser_i | input | 1 | Serial data bit for shift mode |
| clk_a_i | input | 1 | First register clock; rising edge updates |
| clk_b_i | input | 1 | Second register clock; rising edge updates |
| rst_i | input | 1 | Asynchronous active-high register clear |
| par_o | output | 1 | Combinational gated odd parity |
| reg_o | output | 1 | Registered output |

## Verification
A fault in the parity tree shows on `par_o` in the same cycle for any word whose bad node lies on the path. It then reaches `reg_o` on the next load edge. A wrong source selection shows on `reg_o` right after the first edge that takes the wrong source. This is visible only when the serial bit, the parity bit and the held value differ, so the stimulus sets them to differ. A reset fault shows at once after `rst_i` rises, or on the first edge after it falls.

// File: rtl/par_pkg.sv
`timescale 1ns/1ps
package par_pkg;

   // Source of the next register value.
   typedef enum logic [1:0] {
      SRC_KEEP   = 2'd0,
      SRC_SERIAL = 2'd1,
      SRC_PARITY = 2'd2
   } reg_src_e;

   // Parity reduction variants.
   localparam int unsigned STYLE_CHAIN = 0;
   localparam int unsigned STYLE_TREE  = 1;

   // Number of tree levels needed for a given leaf count.
   function automatic int unsigned tree_levels(input int unsigned leaves);
      return (leaves <= 1) ? 0 : $clog2(leaves);
   endfunction

endpackage

// File: rtl/par_xor_tree.sv
`timescale 1ns/1ps
module par_xor_tree
   import par_pkg::*;
#(
   parameter int unsigned WIDTH = 12,
   parameter int unsigned STYLE = STYLE_TREE
) (
   input  logic [WIDTH-1:0] din,
   output logic             odd
);

   localparam int unsigned LEVELS = tree_levels(WIDTH);
   localparam int unsigned PAD    = 1 << LEVELS;

   if (WIDTH < 1) begin : g_bad_width
      $error("par_xor_tree: WIDTH must be at least 1");
   end
   if (STYLE != STYLE_CHAIN && STYLE != STYLE_TREE) begin : g_bad_style
      $error("par_xor_tree: unknown STYLE");
   end

   if (STYLE == STYLE_CHAIN) begin : g_chain
      // Ripple chain: shortest wiring, depth grows with WIDTH.
      logic link [0:WIDTH];
      assign link[0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_link
         assign link[i+1] = link[i] ^ din[i];
      end
      assign odd = link[WIDTH];
   end else begin : g_tree
      // Balanced binary tree padded to a power of two; node 1 is the root.
      logic node [1:2*PAD-1];
      for (genvar i = 0; i < PAD; i++) begin : g_leaf
         if (i < WIDTH) begin : g_real
            assign node[PAD+i] = din[i];
         end else begin : g_zero
            assign node[PAD+i] = 1'b0;
         end
      end
      for (genvar k = 1; k < PAD; k++) begin : g_inner
         assign node[k] = node[2*k] ^ node[2*k+1];
      end
      assign odd = node[1];
   end

endmodule

// File: rtl/par_next_sel.sv
`timescale 1ns/1ps
module par_next_sel
   import par_pkg::*;
(
   input  logic hold_n,
   input  logic shift,
   input  logic cur,
   input  logic ser,
   input  logic par,
   output logic nxt
);

   reg_src_e src;

   // Hold outranks shift; shift outranks the parity reload.
   always_comb begin
      if (!hold_n)    src = SRC_KEEP;
      else if (shift) src = SRC_SERIAL;
      else            src = SRC_PARITY;
   end

   always_comb begin
      unique case (src)
         SRC_KEEP:   nxt = cur;
         SRC_SERIAL: nxt = ser;
         SRC_PARITY: nxt = par;
         default:    nxt = cur;
      endcase
   end

endmodule

// File: rtl/par_dual_clk_reg.sv
`timescale 1ns/1ps
module par_dual_clk_reg (
   input  logic clk_a,
   input  logic clk_b,
   input  logic rst,
   input  logic d,
   output logic q
);

   logic clk_any;

   // Either clock edge advances the register.
   assign clk_any = clk_a | clk_b;

   always_ff @(posedge clk_any or posedge rst) begin
      if (rst) q <= 1'b0;
      else     q <= d;
   end

endmodule

// File: rtl/par_shift_gen.sv
`timescale 1ns/1ps
module par_shift_gen
   import par_pkg::*;
#(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned STYLE  = STYLE_TREE
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              force_lo_i,
   input  logic              hold_n_i,
   input  logic              shift_i,
   input  logic              ser_i,
   input  logic              clk_a_i,
   input  logic              clk_b_i,
   input  logic              rst_i,
   output logic              par_o,
   output logic              reg_o
);

   if (DATA_W != 12) begin : g_width_check
      $error("par_shift_gen: DATA_W must be 12");
   end

   logic odd_raw;
   logic reg_nxt;

   par_xor_tree #(
      .WIDTH (DATA_W),
      .STYLE (STYLE)
   ) u_tree (
      .din (data_i),
      .odd (odd_raw)
   );

   assign par_o = force_lo_i ? 1'b0 : odd_raw;

   par_next_sel u_sel (
      .hold_n (hold_n_i),
      .shift  (shift_i),
      .cur    (reg_o),
      .ser    (ser_i),
      .par    (par_o),
      .nxt    (reg_nxt)
   );

   par_dual_clk_reg u_reg (
      .clk_a (clk_a_i),
      .clk_b (clk_b_i),
      .rst   (rst_i),
      .d     (reg_nxt),
      .q     (reg_o)
   );

endmodule

// File: rtl/par_shift_gen_chk.sv
`timescale 1ns/1ps
module par_shift_gen_chk #(
   parameter int unsigned DATA_W = 12
) (
   input logic [DATA_W-1:0] data_i,
   input logic              force_lo_i,
   input logic              hold_n_i,
   input logic              shift_i,
   input logic              ser_i,
   input logic              clk_a_i,
   input logic              clk_b_i,
   input logic              rst_i,
   input logic              par_o,
   input logic              reg_o
);

   logic clk_any;
   logic rst_gap;

   assign clk_any = clk_a_i | clk_b_i;

   // Set by any reset pulse since the last edge. A reset between edges clears reg_o legitimately.
   always_ff @(posedge clk_any or posedge rst_i) begin
      if (rst_i) rst_gap <= 1'b1;
      else       rst_gap <= 1'b0;
   end

   a_r1_odd_parity: assert property (@(posedge clk_any)
      !force_lo_i |-> (par_o == (^data_i)));

   a_r2_force_low: assert property (@(posedge clk_any)
      force_lo_i |-> !par_o);

   a_r3_hold_keeps: assert property (@(posedge clk_any) disable iff (rst_i)
      !hold_n_i |=> (rst_gap || $stable(reg_o)));

   a_r4_hold_beats_shift: assert property (@(posedge clk_any) disable iff (rst_i)
      (!hold_n_i && shift_i && (ser_i != reg_o)) |=> (rst_gap || $stable(reg_o)));

   a_r5_shift_loads: assert property (@(posedge clk_any) disable iff (rst_i)
      (hold_n_i && shift_i) |=> (rst_gap || (reg_o == $past(ser_i))));

   a_r6_parity_loads: assert property (@(posedge clk_any) disable iff (rst_i)
      (hold_n_i && !shift_i) |=> (rst_gap || (reg_o == $past(par_o))));

   a_r8_reset_clears: assert property (@(posedge clk_any)
      rst_i |-> !reg_o);

endmodule

bind par_shift_gen par_shift_gen_chk #(.DATA_W(DATA_W)) u_chk (
   .data_i     (data_i),
   .force_lo_i (force_lo_i),
   .hold_n_i   (hold_n_i),
   .shift_i    (shift_i),
   .ser_i      (ser_i),
   .clk_a_i    (clk_a_i),
   .clk_b_i    (clk_b_i),
   .rst_i      (rst_i),
   .par_o      (par_o),
   .reg_o      (reg_o)
);

// File: tb/par_shift_gen_test.sv
`timescale 1ns/1ps
module par_shift_gen_test;

   localparam int DW = 12;
   localparam int NV = 15;
   // Vector fields: [15] force, [14] hold_n, [13] shift, [12] ser, [11:0] data
   localparam logic [15:0] VECS [0:NV-1] = '{
      16'h4000, 16'h4FFF, 16'h4001, 16'h0555, 16'h4557,
      16'hC557, 16'h7ABC, 16'h6ABC, 16'h37FF, 16'h4800,
      16'h4F0F, 16'h40F1, 16'h4123, 16'hF000, 16'h2AAA
   };

   logic [DW-1:0] data_i;
   logic force_lo_i, hold_n_i, shift_i, ser_i;
   logic clk_a_i, clk_b_i, rst_i;
   logic par_o, reg_o;

   int checks = 0;
   int fails  = 0;
   logic model;

   par_shift_gen uut (
      .data_i (data_i), .force_lo_i (force_lo_i), .hold_n_i (hold_n_i),
      .shift_i (shift_i), .ser_i (ser_i), .clk_a_i (clk_a_i),
      .clk_b_i (clk_b_i), .rst_i (rst_i), .par_o (par_o), .reg_o (reg_o)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One 4 ns register clock period (250 MHz); sel 0 = A, 1 = B, 2 = both.
   task automatic pulse(input int sel);
      #1;
      if (sel != 1) clk_a_i = 1'b1;
      if (sel != 0) clk_b_i = 1'b1;
      #2;
      clk_a_i = 1'b0;
      clk_b_i = 1'b0;
      #1;
   endtask

   function automatic logic ref_par(input logic [15:0] v);
      return v[15] ? 1'b0 : ^v[DW-1:0];
   endfunction

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      data_i = '0; force_lo_i = 0; hold_n_i = 1; shift_i = 0; ser_i = 0;
      clk_a_i = 0; clk_b_i = 0; rst_i = 1;
      #2;
      chk("R8 reset state", reg_o, 1'b0);
      chk("R1 zero word", par_o, 1'b0);
      pulse(0);
      #1;
      chk("R8 edge during reset", reg_o, 1'b0);
      rst_i = 0;
      #2;
      model = 1'b0;

      // Table walk: R1, R2, R3, R4, R5, R6, R7
      for (int i = 0; i < NV; i++) begin
         logic [15:0] v;
         v = VECS[i];
         force_lo_i = v[15]; hold_n_i = v[14]; shift_i = v[13]; ser_i = v[12];
         data_i = v[DW-1:0];
         #1;
         chk(v[15] ? "R2 forced low" : "R1 parity", par_o, ref_par(v));
         if (!v[14])      model = model;
         else if (v[13])  model = v[12];
         else             model = ref_par(v);
         if (i == 0) begin
            // first edge: clk_a only
         end
         #1; clk_a_i = (i % 3 != 1); clk_b_i = (i % 3 != 0);
         #1;
         chk(!v[14] ? (v[13] ? "R4 hold over shift" : "R3 hold")
                    : (v[13] ? "R5 shift" : "R6 parity load"), reg_o, model);
         chk("R7 clock select edge", reg_o, model);
         #1; clk_a_i = 0; clk_b_i = 0;
         #1;
      end

      // R7: each clock alone and both, loading distinct values
      hold_n_i = 1; shift_i = 1; force_lo_i = 0;
      ser_i = 1; pulse(1); chk("R7 clk_b alone", reg_o, 1'b1);
      ser_i = 0; pulse(0); chk("R7 clk_a alone", reg_o, 1'b0);
      ser_i = 1; pulse(2); chk("R7 both clocks", reg_o, 1'b1);

      // R8: asynchronous clear with no clock edge
      #1; rst_i = 1; #1;
      chk("R8 async clear", reg_o, 1'b0);
      ser_i = 1; pulse(2);
      chk("R8 clocks ignored in reset", reg_o, 1'b0);

      // R9: release between edges, stays low until next edge
      #1; rst_i = 0; #1;
      chk("R9 low after release", reg_o, 1'b0);
      #1;
      chk("R9 still low before edge", reg_o, 1'b0);
      pulse(0);
      chk("R9 loads on next edge", reg_o, 1'b1);

      // R4: hold low with shift and opposite serial bit
      hold_n_i = 0; shift_i = 1; ser_i = 0; pulse(1);
      chk("R4 hold over shift directed", reg_o, 1'b1);

      // R6/R2: forced parity loads zero
      hold_n_i = 1; shift_i = 0; force_lo_i = 1; data_i = 12'h001; pulse(0);
      chk("R6 forced load zero", reg_o, 1'b0);
      force_lo_i = 0; #1;
      chk("R1 single bit", par_o, 1'b1);
      pulse(2);
      chk("R6 parity load", reg_o, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule